// File: doc/BRIEF.md
# Ultrasonic Burst Pulse Generator

This block emits a finite train of square pulses on one output pin. The pin typically switches an external transistor that excites an ultrasonic transducer. Software writes a divider, a pulse count, a high time and a control word through a small write port. Setting the start bit in the control word launches the train. The block counts the pulses, stops by itself, and raises a done flag.

Each pulse lasts a fixed number of timebase ticks, set by the `PULSE_TICKS` parameter (default 16). The timebase comes from one of two sources. The first is the system clock divided by a programmable integer. The second is an external tick strobe that stands in for a phase-locked fractional-rate clock. The output polarity can be inverted. Between bursts the output can either be driven at its inactive level or released, in which case the output enable drops.

Register map (write only, `wr_addr`):

- 0 is control: bit 0 starts a burst, bit 1 selects the external tick source, bit 2 inverts the output, bit 3 releases the pin while idle.
- 1 is the divider, 4 bits.
- 2 is the pulse count, 8 bits.
- 3 is the high time, 10 bits.

Top module: `burst_pulse_gen`

## Requirements
- R1: After synchronous reset, `burst_out` is 0, `burst_oe` is 1, and `busy` and `done` are 0.
- R2: With the system-clock source and divider value N, each timebase tick takes N+1 cycles. A burst of C pulses keeps `busy` high for exactly C·PULSE_TICKS·(N+1) cycles, starting in the cycle after the start write.
- R3: With the external source (control bit 1 set in the start write), the burst advances only in cycles where `alt_tick` is 1. While `alt_tick` stays 0, `busy` and the output hold their values.
- R4: A burst with count C and a high time between 1 and PULSE_TICKS−1 produces exactly C active pulses on `burst_out`.
- R5: In each pulse the output is active while the tick index inside the pulse is below the high time. A high time of PULSE_TICKS or more keeps the output active for the whole burst.
- R6: Control bit 2 inverts the output. The idle level of `burst_out` equals that bit, and the bit takes effect at once.
- R7: `burst_oe` is 1 whenever `busy` is 1. While idle, `burst_oe` is 0 if control bit 3 is set and 1 if it is clear.
- R8: When the last tick of the last pulse occurs, `busy` falls and `done` rises on the same edge, and the output returns to its inactive level. `busy` and `done` are never 1 together.
- R9: A start request while `busy` is 1 is ignored. Writes to the divider, count or high-time registers during a burst do not affect that burst; they are used from the next start onward.
- R10: A start with count 0 sets `done` on the next edge, leaves `busy` at 0, and causes no activity on the output.
- R11: A start with a nonzero count clears `done` and sets `busy` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 10 | Write data |
| alt_tick | input | 1 | External timebase strobe, one cycle per tick |
| burst_out | output | 1 | Burst output pin |
| burst_oe | output | 1 | Output enable for the burst pin |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst has completed |

## Verification
The hardest situation to reach is a register write that arrives while a burst is running. A new divider, a new count and a repeated start must all be presented mid-burst. The burst length must then show that none of them took effect until the following start. The stimulus launches a burst and immediately writes new values and a second start while `busy` is high. It then measures both that burst and the next one against lengths computed from the old and the new settings. The external-source case is driven by a strobe generator that the bench can stall for tens of cycles, to show that the output freezes while no tick arrives.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int DIV_W  = 4;
    localparam int CNT_W  = 8;
    localparam int HIGH_W = 10;
    localparam int ADDR_W = 2;
    localparam int DATA_W = HIGH_W;

    localparam int CTRL_START = 0;
    localparam int CTRL_ALT   = 1;
    localparam int CTRL_INV   = 2;
    localparam int CTRL_FLOAT = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_DIV   = 2'd1,
        REG_COUNT = 2'd2,
        REG_HIGH  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              alt;
        logic [DIV_W-1:0]  div;
        logic [CNT_W-1:0]  count;
        logic [HIGH_W-1:0] high;
    } burst_cfg_t;

    function automatic logic drive_level(input logic active, input logic inv);
        return active ^ inv;
    endfunction
endpackage

// File: rtl/burst_regs.sv
module burst_regs
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output burst_cfg_t        run_cfg,
    output logic              start,
    output logic [CNT_W-1:0]  start_count,
    output logic              inv,
    output logic              flt
);
    burst_cfg_t shadow;

    assign start       = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL) && wr_data[CTRL_START] && !busy;
    assign start_count = shadow.count;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            run_cfg <= '0;
            inv     <= 1'b0;
            flt     <= 1'b0;
        end else begin
            if (wr_en) begin
                case (reg_sel_e'(wr_addr))
                    REG_CTRL: begin
                        inv <= wr_data[CTRL_INV];
                        flt <= wr_data[CTRL_FLOAT];
                    end
                    REG_DIV:   shadow.div   <= wr_data[DIV_W-1:0];
                    REG_COUNT: shadow.count <= wr_data[CNT_W-1:0];
                    REG_HIGH:  shadow.high  <= wr_data[HIGH_W-1:0];
                    default: ;
                endcase
            end
            if (start) begin
                run_cfg     <= shadow;
                run_cfg.alt <= wr_data[CTRL_ALT];
            end
        end
    end
endmodule

// File: rtl/burst_timebase.sv
module burst_timebase
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             alt_sel,
    input  logic             alt_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] dcnt;
    logic             wrap;

    assign wrap = (dcnt == div);
    assign tick = alt_sel ? alt_tick : wrap;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            dcnt <= '0;
        end else if (run) begin
            dcnt <= wrap ? '0 : dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import burst_pkg::*;
#(
    parameter int PULSE_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              tick,
    input  logic [CNT_W-1:0]  count,
    input  logic [HIGH_W-1:0] high,
    output logic              busy,
    output logic              done,
    output logic              active
);
    localparam int PH_W = (PULSE_TICKS > 2) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PULSE_TICKS - 1);

    logic [PH_W-1:0]  ph;
    logic [CNT_W-1:0] pc;

    assign active = busy && (HIGH_W'(ph) < high);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            ph   <= '0;
            pc   <= '0;
        end else if (start) begin
            ph   <= '0;
            pc   <= '0;
            busy <= (start_count != '0);
            done <= (start_count == '0);
        end else if (busy && tick) begin
            if (ph == PH_LAST) begin
                ph <= '0;
                if (pc == count - CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    pc <= pc + 1'b1;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen
    import burst_pkg::*;
#(
    parameter int PULSE_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alt_tick,
    output logic              burst_out,
    output logic              burst_oe,
    output logic              busy,
    output logic              done
);
    burst_cfg_t       run_cfg;
    logic             start;
    logic [CNT_W-1:0] start_count;
    logic             inv;
    logic             flt;
    logic             tick;
    logic             active;

    burst_regs i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .run_cfg(run_cfg), .start(start), .start_count(start_count),
        .inv(inv), .flt(flt)
    );

    burst_timebase i_timebase (
        .clk(clk), .rst(rst), .clear(start), .run(busy), .alt_sel(run_cfg.alt),
        .alt_tick(alt_tick), .div(run_cfg.div), .tick(tick)
    );

    burst_sequencer #(.PULSE_TICKS(PULSE_TICKS)) i_seq (
        .clk(clk), .rst(rst), .start(start), .start_count(start_count), .tick(tick),
        .count(run_cfg.count), .high(run_cfg.high), .busy(busy), .done(done),
        .active(active)
    );

    assign burst_out = drive_level(active, inv);
    assign burst_oe  = busy | ~flt;
endmodule

module burst_pulse_gen_chk
    import burst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             burst_out,
    input logic             burst_oe,
    input logic             inv,
    input logic             flt,
    input logic             start,
    input logic [CNT_W-1:0] start_count,
    input logic             alt_tick,
    input logic             active,
    input burst_cfg_t       run_cfg
);
    p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (burst_out == inv));

    p_oe_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> burst_oe);

    p_oe_float_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && flt) |-> !burst_oe);

    p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    p_finish_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(run_cfg)));

    p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
        (start && start_count == '0) |=> (done && !busy));

    p_start_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (start && start_count != '0) |=> (busy && !done));

    p_alt_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && run_cfg.alt && !alt_tick) |=> (busy && $stable(active)));
endmodule

bind burst_pulse_gen burst_pulse_gen_chk i_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .burst_out(burst_out),
    .burst_oe(burst_oe), .inv(inv), .flt(flt), .start(start),
    .start_count(start_count), .alt_tick(alt_tick), .active(active), .run_cfg(run_cfg)
);

// File: tb/test_burst_pulse_gen.sv
module test_burst_pulse_gen;
    localparam int CLK_PERIOD = 10;
    localparam int P = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic       alt_tick = 1'b0;
    logic       burst_out, burst_oe, busy, done;

    int  n_chk = 0, n_fail = 0, cyc = 0, edges = 0;
    bit  prev_out = 1'b0, alt_mode = 1'b0, alt_hold = 1'b0, finished = 1'b0;

    // behavioural reference state
    int  m_div, m_cnt, m_high, r_div, r_cnt, r_high, m_sub, m_ticks;
    bit  m_inv, m_flt, r_alt, m_busy, m_done;

    burst_pulse_gen #(.PULSE_TICKS(P)) i_burst_pulse_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alt_tick(alt_tick), .burst_out(burst_out), .burst_oe(burst_oe),
        .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 10'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // reference model: advances on each rising edge from the applied inputs
    always @(posedge clk) begin
        bit was_busy, tk;
        cyc++;
        if (rst) begin
            m_div = 0; m_cnt = 0; m_high = 0; r_div = 0; r_cnt = 0; r_high = 0;
            m_sub = 0; m_ticks = 0; m_inv = 0; m_flt = 0; r_alt = 0;
            m_busy = 0; m_done = 0;
        end else begin
            was_busy = m_busy;
            if (m_busy) begin
                tk = r_alt ? alt_tick : (m_sub == r_div);
                if (tk) begin
                    m_sub = 0;
                    m_ticks++;
                    if (m_ticks == r_cnt * P) begin
                        m_busy = 0;
                        m_done = 1;
                    end
                end else begin
                    m_sub++;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_inv = wr_data[2];
                        m_flt = wr_data[3];
                        if (wr_data[0] && !was_busy) begin
                            if (m_cnt == 0) begin
                                m_done = 1;
                            end else begin
                                m_busy = 1; m_done = 0;
                                r_div = m_div; r_cnt = m_cnt; r_high = m_high;
                                r_alt = wr_data[1]; m_sub = 0; m_ticks = 0;
                            end
                        end
                    end
                    2'd1: m_div = int'(wr_data[3:0]);
                    2'd2: m_cnt = int'(wr_data[7:0]);
                    default: m_high = int'(wr_data);
                endcase
            end
        end
    end

    // compare every cycle, edge counting, external strobe generation
    always @(negedge clk) begin
        bit e_act;
        if (!rst && !finished) begin
            e_act = m_busy && ((m_ticks % P) < m_high);
            chk("R2 busy", int'(busy), int'(m_busy));
            chk("R8 done", int'(done), int'(m_done));
            chk("R5/R6 burst_out", int'(burst_out), int'(e_act ^ m_inv));
            chk("R7 burst_oe", int'(burst_oe), int'(m_busy || !m_flt));
        end
        if (burst_out && !prev_out) edges++;
        prev_out = burst_out;
        alt_tick = alt_mode && !alt_hold && (cyc % 3 == 0);
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual %0d expected <= 100000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out", int'(burst_out), 0);
        chk("R1 oe", int'(burst_oe), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);

        // R10: zero count completes at once
        edges = 0;
        wr(0, 1);
        chk("R10 done", int'(done), 1);
        chk("R10 busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R10 edges", edges, 0);

        // R2/R4: divider 0, three pulses, high 4
        wr(2, 3); wr(1, 0); wr(3, 4);
        edges = 0;
        wr(0, 1);
        chk("R11 done cleared", int'(done), 0);
        chk("R11 busy set", int'(busy), 1);
        t0 = cyc;
        wait_idle();
        chk("R2 length div0", cyc - t0, 3 * P * 1);
        chk("R4 pulses", edges, 3);
        chk("R8 done", int'(done), 1);

        // R2: divider 5, two pulses
        wr(1, 5); wr(2, 2); wr(3, 8);
        edges = 0;
        wr(0, 1); t0 = cyc;
        wait_idle();
        chk("R2 length div5", cyc - t0, 2 * P * 6);
        chk("R4 pulses div5", edges, 2);

        // R5: high time beyond the period
        wr(1, 0); wr(2, 3); wr(3, 20);
        edges = 0;
        wr(0, 1); t0 = cyc;
        wait_idle();
        chk("R5 full-high edges", edges, 1);
        chk("R5 length", cyc - t0, 3 * P);

        // R6/R7: inverted, released while idle
        wr(0, 4 | 8);
        chk("R6 idle level inverted", int'(burst_out), 1);
        chk("R7 released when idle", int'(burst_oe), 0);
        wr(3, 4); wr(2, 1);
        wr(0, 1 | 4 | 8);
        chk("R7 driven while busy", int'(burst_oe), 1);
        chk("R6 active level inverted", int'(burst_out), 0);
        wait_idle();
        chk("R7 released after", int'(burst_oe), 0);
        wr(0, 0);
        chk("R6 restored level", int'(burst_out), 0);

        // R3: external tick source with a stall
        alt_mode = 1'b1; alt_hold = 1'b1;
        wr(2, 2); wr(3, 5);
        wr(0, 2 | 1);
        repeat (40) @(negedge clk);
        chk("R3 stalled busy", int'(busy), 1);
        chk("R3 stalled out", int'(burst_out), 1);
        alt_hold = 1'b0;
        wait_idle();
        chk("R3 done", int'(done), 1);
        alt_mode = 1'b0;

        // R9: mid-burst writes and a repeated start
        wr(1, 0); wr(2, 4); wr(3, 4);
        wr(0, 1); t0 = cyc;
        wr(2, 1); wr(1, 9); wr(0, 1);
        wait_idle();
        chk("R9 burst unchanged", cyc - t0, 4 * P);
        wr(0, 1); t0 = cyc;
        wait_idle();
        chk("R9 new settings used", cyc - t0, 1 * P * 10);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule